// File: doc/BRIEF.md
# Handset Power Mode Sequencer

This block follows the power mode of a handset energy-management chip and switches its regulators on in a fixed order. Its inputs are already-digitized comparator flags for the battery and backup supply, plus the wake sources (power key, charger detect, clock alarm), an active-low sleep request, watchdog expiry flags and a thermal fault. A tick input sets the timebase, and every delay is a parameter counted in ticks. Simulation can therefore use short delays while silicon uses the real ones.

The mode codes are: 0 no-supply, 1 backup, 2 off, 3 reset, 4 on and 5 sleep. In reset, a guard timer runs until the battery passes the power-up level. The flash supply then comes up first, and after that the analog, IO, core and RF supplies together. After a settle time the block enters the on mode. Two hold filters watch for a long enough battery dip and a long enough sleep request. A small bank of software regulator enables can be written only while the block is on or asleep.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is asserted and directly after it, the mode is 0 (no-supply), and every regulator enable and every software enable is 0.
- R2: In mode 0 or mode 1, `vbat_above_hi` moves the block to mode 3 at the next clock. In mode 1, losing `backup_ok` while `vbat_above_hi` is low moves it to mode 0.
- R3: In modes 2, 3, 4 and 5, `vbat_below_lo` has the highest priority. It moves the block to mode 1 if `backup_ok` is high, or to mode 0 if `backup_ok` is low.
- R4: In mode 2, a single-cycle pulse on `key_press`, `charger_in` or `alarm_in` is latched. The block enters mode 3 once WAKE_TICKS ticks have passed after the cycle that sampled the pulse.
- R5: In mode 3, if `vbat_pwrup_ok` stays low for GUARD_TICKS ticks after entry, the block returns to mode 2.
- R6: Once `vbat_pwrup_ok` is seen in mode 3, `flash_en` rises after FLASH_TICKS ticks. `ana_en`, `io_en`, `core_en` and `rf_en` rise CORE_TICKS ticks after that. Mode 4 follows SETTLE_TICKS ticks later.
- R7: Regulator enables by mode, read as {rtc,flash,ana,io,core,rf}: mode 0 gives 000000, modes 1 and 2 give 100000, mode 4 gives 111111, and mode 5 gives 110110.
- R8: In mode 4, `vbat_below_cut` held for more than CUTOFF_TICKS ticks sends the block to mode 2. A burst of at most CUTOFF_TICKS ticks has no effect.
- R9: In mode 4, `sleep_req_n` held low for more than SLEEP_TICKS ticks sends the block to mode 5. Shorter bursts have no effect, and a low sleep request in any other mode has no effect.
- R10: In mode 5, `sleep_req_n` high returns the block to mode 4 at the next clock.
- R11: Any bit of `wdog_expired` moves the block to mode 2 from modes 3, 4 and 5. `thermal_fault` does the same from modes 4 and 5. Both inputs are ignored in modes 0 and 1.
- R12: `sw_wr` loads `sw_wdata` into `sw_en` only in modes 4 and 5. `sw_en` is cleared when the block leaves those modes, and a write in any other mode is ignored.
- R13: No delay counter or hold filter advances in a cycle where `tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable for all delays |
| vbat_above_hi | input | 1 | Battery above upper master-reset threshold |
| vbat_below_lo | input | 1 | Battery below lower master-reset threshold |
| backup_ok | input | 1 | Backup supply present |
| vbat_pwrup_ok | input | 1 | Battery above power-up level |
| vbat_below_cut | input | 1 | Battery below cutoff level |
| key_press | input | 1 | Power key |
| charger_in | input | 1 | Charger detected |
| alarm_in | input | 1 | Clock alarm |
| sleep_req_n | input | 1 | Sleep request, active low |
| wdog_expired | input | N_WDOG | Watchdog expiry flags |
| thermal_fault | input | 1 | Regulator over-temperature |
| sw_wr | input | 1 | Software enable write strobe |
| sw_wdata | input | N_SWREG | Software enable write data |
| mode | output | 3 | Current mode code |
| rtc_en | output | 1 | Clock supply enable |
| flash_en | output | 1 | Flash supply enable |
| ana_en | output | 1 | Analog supply enable |
| io_en | output | 1 | IO supply enable |
| core_en | output | 1 | Core supply enable |
| rf_en | output | 1 | RF supply enable |
| sw_en | output | N_SWREG | Software-controlled regulator enables |

## Verification
The hardest part to reach is the staged ramp inside mode 3. The bench has to get through off, then a latched wake, and then the guard. Each later stage only shows up as a single enable edge at a tick count that depends on the stages before it. The bench drives a wake pulse with the power-up flag set and counts cycles to each enable edge, comparing them with sums of the delay parameters. It also holds the tick low partway through to show the count freezes. The hold-filter limits are probed from the on mode with random bursts that never exceed the limit, followed by one burst held until the filter trips.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   typedef enum logic [2:0] {
      M_NOSUP  = 3'd0,
      M_BACKUP = 3'd1,
      M_OFF    = 3'd2,
      M_RESET  = 3'd3,
      M_ON     = 3'd4,
      M_SLEEP  = 3'd5
   } pmode_t;

   typedef enum logic [1:0] {
      PH_GUARD  = 2'd0,
      PH_RAMP1  = 2'd1,
      PH_RAMP2  = 2'd2,
      PH_SETTLE = 2'd3
   } rphase_t;

   typedef struct packed {
      logic rtc;
      logic flash;
      logic ana;
      logic io;
      logic core;
      logic rf;
   } regen_t;

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R6
   load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !zero);

   // R13
   tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/pwrseq_lowfilt.sv
module pwrseq_lowfilt #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic en,
   input  logic cond,
   output logic trip
);

   localparam int CW = $clog2(LIMIT + 2);
   localparam logic [CW-1:0] TOP = CW'(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (!(en && cond))        cnt_q <= '0;
      else if (tick && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign trip = (cnt_q == TOP);

   // R8
   trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trip) |-> $past(en && cond && tick));

   // R13
   filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && en && cond) |=> $stable(cnt_q));

endmodule

// File: rtl/pwrseq_regmap.sv
module pwrseq_regmap
   import pwrseq_pkg::*;
#(
   parameter int N_SWREG     = 4,
   parameter bit SLEEP_RF_ON = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  pmode_t             mode_q,
   input  pmode_t             mode_d,
   input  rphase_t            phase_q,
   input  logic               sw_wr,
   input  logic [N_SWREG-1:0] sw_wdata,
   output regen_t             regs,
   output logic [N_SWREG-1:0] sw_en
);

   logic rf_in_sleep;
   logic live_q, live_d;

   generate
      if (SLEEP_RF_ON) begin : g_rf_keep
         assign rf_in_sleep = 1'b1;
      end else begin : g_rf_drop
         assign rf_in_sleep = 1'b0;
      end
   endgenerate

   always_comb begin
      regs = '0;
      unique case (mode_q)
         M_NOSUP: regs = '0;
         M_BACKUP, M_OFF: regs.rtc = 1'b1;
         M_RESET: begin
            regs.rtc   = 1'b1;
            regs.flash = (phase_q == PH_RAMP2) || (phase_q == PH_SETTLE);
            regs.ana   = (phase_q == PH_SETTLE);
            regs.io    = (phase_q == PH_SETTLE);
            regs.core  = (phase_q == PH_SETTLE);
            regs.rf    = (phase_q == PH_SETTLE);
         end
         M_ON: regs = '1;
         M_SLEEP: begin
            regs.rtc   = 1'b1;
            regs.flash = 1'b1;
            regs.io    = 1'b1;
            regs.core  = 1'b1;
            regs.rf    = rf_in_sleep;
         end
         default: regs = '0;
      endcase
   end

   assign live_q = (mode_q == M_ON) || (mode_q == M_SLEEP);
   assign live_d = (mode_d == M_ON) || (mode_d == M_SLEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              sw_en <= '0;
      else if (!live_d)        sw_en <= '0;
      else if (sw_wr && live_q) sw_en <= sw_wdata;
   end

   // R12
   sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && live_q && live_d) |=> (sw_en == $past(sw_wdata)));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pwrseq_pkg::*;
#(
   parameter int TW           = 18,
   parameter int WAKE_TICKS   = 20000,
   parameter int GUARD_TICKS  = 50000,
   parameter int FLASH_TICKS  = 200000,
   parameter int CORE_TICKS   = 500,
   parameter int SETTLE_TICKS = 20000,
   parameter int CUTOFF_TICKS = 5,
   parameter int SLEEP_TICKS  = 60,
   parameter int N_WDOG       = 3,
   parameter int N_SWREG      = 4,
   parameter bit SLEEP_RF_ON  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               vbat_above_hi,
   input  logic               vbat_below_lo,
   input  logic               backup_ok,
   input  logic               vbat_pwrup_ok,
   input  logic               vbat_below_cut,
   input  logic               key_press,
   input  logic               charger_in,
   input  logic               alarm_in,
   input  logic               sleep_req_n,
   input  logic [N_WDOG-1:0]  wdog_expired,
   input  logic               thermal_fault,
   input  logic               sw_wr,
   input  logic [N_SWREG-1:0] sw_wdata,
   output logic [2:0]         mode,
   output logic               rtc_en,
   output logic               flash_en,
   output logic               ana_en,
   output logic               io_en,
   output logic               core_en,
   output logic               rf_en,
   output logic [N_SWREG-1:0] sw_en
);

   localparam logic [TW-1:0] T_WAKE   = TW'(WAKE_TICKS);
   localparam logic [TW-1:0] T_GUARD  = TW'(GUARD_TICKS);
   localparam logic [TW-1:0] T_FLASH  = TW'(FLASH_TICKS);
   localparam logic [TW-1:0] T_CORE   = TW'(CORE_TICKS);
   localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_TICKS);
   localparam int            T_LIMIT  = 1 << TW;

   initial begin
      assert (WAKE_TICKS   >= 1 && WAKE_TICKS   < T_LIMIT) else $error("WAKE_TICKS out of range");
      assert (GUARD_TICKS  >= 1 && GUARD_TICKS  < T_LIMIT) else $error("GUARD_TICKS out of range");
      assert (FLASH_TICKS  >= 1 && FLASH_TICKS  < T_LIMIT) else $error("FLASH_TICKS out of range");
      assert (CORE_TICKS   >= 1 && CORE_TICKS   < T_LIMIT) else $error("CORE_TICKS out of range");
      assert (SETTLE_TICKS >= 1 && SETTLE_TICKS < T_LIMIT) else $error("SETTLE_TICKS out of range");
      assert (CUTOFF_TICKS >= 1 && SLEEP_TICKS >= 1)        else $error("filter limits must be positive");
      assert (N_WDOG >= 1 && N_SWREG >= 1)                  else $error("bank widths must be positive");
   end

   pmode_t  mode_q, mode_d;
   rphase_t phase_q, phase_d;
   logic    pend_q, pend_d;
   logic    tload;
   logic [TW-1:0] tval;
   logic    tzero;
   logic    cut_trip, slp_trip;
   logic    any_wd, wake, lost;
   pmode_t  drop_mode;
   regen_t  regs;

   assign any_wd    = |wdog_expired;
   assign wake      = key_press | charger_in | alarm_in;
   assign lost      = vbat_below_lo;
   assign drop_mode = backup_ok ? M_BACKUP : M_NOSUP;

   pwrseq_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (tload),
      .load_val (tval),
      .zero     (tzero)
   );

   pwrseq_lowfilt #(.LIMIT(CUTOFF_TICKS)) u_cut_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .en    (mode_q == M_ON),
      .cond  (vbat_below_cut),
      .trip  (cut_trip)
   );

   pwrseq_lowfilt #(.LIMIT(SLEEP_TICKS)) u_slp_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .en    (mode_q == M_ON),
      .cond  (!sleep_req_n),
      .trip  (slp_trip)
   );

   always_comb begin
      mode_d  = mode_q;
      phase_d = phase_q;
      pend_d  = pend_q;
      tload   = 1'b0;
      tval    = '0;
      unique case (mode_q)
         M_NOSUP, M_BACKUP: begin
            if (vbat_above_hi) begin
               mode_d  = M_RESET;
               phase_d = PH_GUARD;
               tload   = 1'b1;
               tval    = T_GUARD;
            end else if (mode_q == M_BACKUP && !backup_ok) begin
               mode_d = M_NOSUP;
            end
         end
         M_OFF: begin
            if (lost) begin
               mode_d = drop_mode;
            end else if (!pend_q) begin
               if (wake) begin
                  pend_d = 1'b1;
                  tload  = 1'b1;
                  tval   = T_WAKE;
               end
            end else if (tzero) begin
               mode_d  = M_RESET;
               phase_d = PH_GUARD;
               tload   = 1'b1;
               tval    = T_GUARD;
            end
         end
         M_RESET: begin
            if (lost) begin
               mode_d = drop_mode;
            end else if (any_wd) begin
               mode_d = M_OFF;
            end else begin
               unique case (phase_q)
                  PH_GUARD: begin
                     if (vbat_pwrup_ok) begin
                        phase_d = PH_RAMP1;
                        tload   = 1'b1;
                        tval    = T_FLASH;
                     end else if (tzero) begin
                        mode_d = M_OFF;
                     end
                  end
                  PH_RAMP1: if (tzero) begin
                     phase_d = PH_RAMP2;
                     tload   = 1'b1;
                     tval    = T_CORE;
                  end
                  PH_RAMP2: if (tzero) begin
                     phase_d = PH_SETTLE;
                     tload   = 1'b1;
                     tval    = T_SETTLE;
                  end
                  PH_SETTLE: if (tzero) mode_d = M_ON;
                  default: phase_d = PH_GUARD;
               endcase
            end
         end
         M_ON: begin
            if (lost)                        mode_d = drop_mode;
            else if (any_wd || thermal_fault) mode_d = M_OFF;
            else if (cut_trip)               mode_d = M_OFF;
            else if (slp_trip)               mode_d = M_SLEEP;
         end
         M_SLEEP: begin
            if (lost)                        mode_d = drop_mode;
            else if (any_wd || thermal_fault) mode_d = M_OFF;
            else if (sleep_req_n)            mode_d = M_ON;
         end
         default: mode_d = M_NOSUP;
      endcase
      if (mode_d != M_OFF) pend_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= M_NOSUP;
         phase_q <= PH_GUARD;
         pend_q  <= 1'b0;
      end else begin
         mode_q  <= mode_d;
         phase_q <= phase_d;
         pend_q  <= pend_d;
      end
   end

   pwrseq_regmap #(.N_SWREG(N_SWREG), .SLEEP_RF_ON(SLEEP_RF_ON)) u_regmap (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_q   (mode_q),
      .mode_d   (mode_d),
      .phase_q  (phase_q),
      .sw_wr    (sw_wr),
      .sw_wdata (sw_wdata),
      .regs     (regs),
      .sw_en    (sw_en)
   );

   assign mode     = mode_q;
   assign rtc_en   = regs.rtc;
   assign flash_en = regs.flash;
   assign ana_en   = regs.ana;
   assign io_en    = regs.io;
   assign core_en  = regs.core;
   assign rf_en    = regs.rf;

   // R6
   on_after_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_ON && $past(mode_q) == M_RESET) |-> $past(core_en && flash_en));

   // R6
   core_after_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(core_en) && mode_q == M_RESET) |-> $past(flash_en));

   // R9
   sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_SLEEP && $past(mode_q) != M_SLEEP) |-> $past(mode_q) == M_ON);

   // R2
   reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_RESET && $past(mode_q) != M_RESET)
         |-> ($past(mode_q) inside {M_NOSUP, M_BACKUP, M_OFF}));

   // R3
   supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(vbat_below_lo) && ($past(mode_q) inside {M_OFF, M_RESET, M_ON, M_SLEEP}))
         |-> (mode_q inside {M_BACKUP, M_NOSUP}));

   // R11
   wdog_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(any_wd) && !$past(vbat_below_lo) && ($past(mode_q) inside {M_RESET, M_ON, M_SLEEP}))
         |-> mode_q == M_OFF);

   // R12
   sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_q inside {M_ON, M_SLEEP}) |-> sw_en == '0);

endmodule

// File: tb/tb_pwr_mode_seq.sv
`timescale 1ns/1ps
module tb_pwr_mode_seq;

   localparam int TW  = 8;
   localparam int WK  = 4;
   localparam int GD  = 10;
   localparam int FL  = 6;
   localparam int CR  = 3;
   localparam int ST  = 5;
   localparam int CUT = 3;
   localparam int SLP = 4;
   localparam int NW  = 3;
   localparam int NS  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic vbat_above_hi = 1'b0, vbat_below_lo = 1'b0, backup_ok = 1'b0;
   logic vbat_pwrup_ok = 1'b0, vbat_below_cut = 1'b0;
   logic key_press = 1'b0, charger_in = 1'b0, alarm_in = 1'b0;
   logic sleep_req_n = 1'b1;
   logic [NW-1:0] wdog_expired = '0;
   logic thermal_fault = 1'b0;
   logic sw_wr = 1'b0;
   logic [NS-1:0] sw_wdata = '0;
   logic [2:0] mode;
   logic rtc_en, flash_en, ana_en, io_en, core_en, rf_en;
   logic [NS-1:0] sw_en;

   int checks = 0;
   int errs   = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pwr_mode_seq #(
      .TW(TW), .WAKE_TICKS(WK), .GUARD_TICKS(GD), .FLASH_TICKS(FL),
      .CORE_TICKS(CR), .SETTLE_TICKS(ST), .CUTOFF_TICKS(CUT),
      .SLEEP_TICKS(SLP), .N_WDOG(NW), .N_SWREG(NS), .SLEEP_RF_ON(1'b0)
   ) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .vbat_above_hi(vbat_above_hi), .vbat_below_lo(vbat_below_lo),
      .backup_ok(backup_ok), .vbat_pwrup_ok(vbat_pwrup_ok),
      .vbat_below_cut(vbat_below_cut), .key_press(key_press),
      .charger_in(charger_in), .alarm_in(alarm_in),
      .sleep_req_n(sleep_req_n), .wdog_expired(wdog_expired),
      .thermal_fault(thermal_fault), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
      .mode(mode), .rtc_en(rtc_en), .flash_en(flash_en), .ana_en(ana_en),
      .io_en(io_en), .core_en(core_en), .rf_en(rf_en), .sw_en(sw_en)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000 && !done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: run hung, actual=%0d expected<=%0d cycles", cyc, 50000);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   function automatic int exp_regs(int m);
      case (m)
         0:       return 6'b000000;
         1, 2:    return 6'b100000;
         4:       return 6'b111111;
         5:       return 6'b110110;
         default: return 6'b100000;
      endcase
   endfunction

   function automatic int obs_regs();
      return {26'd0, rtc_en, flash_en, ana_en, io_en, core_en, rf_en};
   endfunction

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_mode(int m, int lim, output int n);
      n = 0;
      while (mode != 3'(m) && n < lim) begin
         step(1);
         n++;
      end
   endtask

   task automatic power_up();
      int n;
      charger_in = 1'b1;
      step(1);
      charger_in = 1'b0;
      wait_mode(4, 200, n);
      chk("R4 power-up reaches on", int'(mode), 4);
   endtask

   initial begin
      int n, t_flash, t_core, t_on, v, len;
      void'($urandom(32'd2024));

      step(3);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 mode after reset", int'(mode), 0);
      chk("R1 enables after reset", obs_regs(), 0);
      chk("R1 sw_en after reset", int'(sw_en), 0);

      // R2 no-supply to reset, then R5 guard expiry
      vbat_above_hi = 1'b1;
      step(1);
      chk("R2 no-supply to reset", int'(mode), 3);
      chk("R7 reset guard stage enables", obs_regs(), 6'b100000);
      wait_mode(2, 100, n);
      chk("R5 guard expiry cycles", n, GD + 1);
      chk("R7 off enables", obs_regs(), exp_regs(2));

      // R9 sleep request ignored in off
      sleep_req_n = 1'b0;
      step(SLP + 5);
      chk("R9 sleep ignored in off", int'(mode), 2);
      sleep_req_n = 1'b1;

      // R12 write ignored in off
      sw_wr = 1'b1; sw_wdata = 4'hA;
      step(1);
      sw_wr = 1'b0;
      chk("R12 write ignored in off", int'(sw_en), 0);

      // R4 wake latch with R13 tick freeze
      vbat_pwrup_ok = 1'b1;
      key_press = 1'b1;
      step(1);
      key_press = 1'b0;
      tick = 1'b0;
      step(20);
      chk("R13 no progress without tick", int'(mode), 2);
      tick = 1'b1;
      wait_mode(3, 100, n);
      chk("R4 wake delay cycles", n + 1, WK + 2);

      // R6 ramp timing
      t_flash = 0; t_core = 0; t_on = 0;
      for (int k = 1; k <= 100 && t_on == 0; k++) begin
         step(1);
         if (flash_en && t_flash == 0) t_flash = k;
         if (core_en && t_core == 0)   t_core = k;
         if (mode == 3'd4 && t_on == 0) t_on = k;
      end
      chk("R6 flash delay", t_flash, FL + 2);
      chk("R6 core group delay", t_core, FL + CR + 3);
      chk("R6 on delay", t_on, FL + CR + ST + 4);
      chk("R7 on enables", obs_regs(), exp_regs(4));

      // R12 random writes in on
      for (int i = 0; i < 5; i++) begin
         v = int'($urandom_range(15, 0));
         sw_wr = 1'b1; sw_wdata = 4'(v);
         step(1);
         sw_wr = 1'b0;
         chk("R12 write in on", int'(sw_en), v);
      end

      // R8 and R9 short random bursts have no effect
      for (int i = 0; i < 8; i++) begin
         len = int'($urandom_range(CUT, 1));
         vbat_below_cut = 1'b1;
         step(len);
         vbat_below_cut = 1'b0;
         step(1 + int'($urandom_range(2, 0)));
         chk("R8 short cutoff burst ignored", int'(mode), 4);
         len = int'($urandom_range(SLP, 1));
         sleep_req_n = 1'b0;
         step(len);
         sleep_req_n = 1'b1;
         step(1 + int'($urandom_range(2, 0)));
         chk("R9 short sleep burst ignored", int'(mode), 4);
      end

      // R9 sleep entry
      sleep_req_n = 1'b0;
      wait_mode(5, 100, n);
      chk("R9 sleep entry cycles", n, SLP + 2);
      chk("R7 sleep enables", obs_regs(), exp_regs(5));
      chk("R12 sw kept in sleep", int'(sw_en), v);

      // R10 wake from sleep
      sleep_req_n = 1'b1;
      step(1);
      chk("R10 sleep exit to on", int'(mode), 4);

      // R8 long cutoff
      vbat_below_cut = 1'b1;
      wait_mode(2, 100, n);
      vbat_below_cut = 1'b0;
      chk("R8 cutoff trip cycles", n, CUT + 2);
      chk("R12 sw cleared on leaving", int'(sw_en), 0);

      // R11 watchdog in on
      power_up();
      wdog_expired = 3'(1 << $urandom_range(NW - 1, 0));
      step(1);
      wdog_expired = '0;
      chk("R11 watchdog in on", int'(mode), 2);

      // R11 thermal in sleep
      power_up();
      sleep_req_n = 1'b0;
      wait_mode(5, 100, n);
      thermal_fault = 1'b1;
      step(1);
      thermal_fault = 1'b0;
      sleep_req_n = 1'b1;
      chk("R11 thermal in sleep", int'(mode), 2);

      // R11 watchdog in reset
      alarm_in = 1'b1;
      step(1);
      alarm_in = 1'b0;
      wait_mode(3, 100, n);
      step(2);
      wdog_expired = 3'b100;
      step(1);
      wdog_expired = '0;
      chk("R11 watchdog in reset", int'(mode), 2);

      // R3 drop from on into backup
      power_up();
      vbat_above_hi = 1'b0;
      backup_ok = 1'b1;
      vbat_below_lo = 1'b1;
      wdog_expired = 3'b111;
      step(1);
      chk("R3 drop to backup", int'(mode), 1);
      step(2);
      wdog_expired = '0;
      chk("R11 watchdog ignored in backup", int'(mode), 1);
      chk("R7 backup enables", obs_regs(), exp_regs(1));

      // R2 backup lost, then recovery
      backup_ok = 1'b0;
      step(1);
      chk("R2 backup to no-supply", int'(mode), 0);
      chk("R7 no-supply enables", obs_regs(), exp_regs(0));
      vbat_below_lo = 1'b0;
      vbat_above_hi = 1'b1;
      step(1);
      chk("R2 recovery to reset", int'(mode), 3);
      wait_mode(4, 200, n);
      chk("R6 reaches on after recovery", int'(mode), 4);

      // R3 drop from sleep without backup
      sleep_req_n = 1'b0;
      wait_mode(5, 100, n);
      vbat_above_hi = 1'b0;
      vbat_below_lo = 1'b1;
      step(1);
      chk("R3 sleep drop to no-supply", int'(mode), 0);
      sleep_req_n = 1'b1;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule